// File: doc/BRIEF.md
# Tile-versus-scalar predicate comparator

This block walks the valid region of a row-major tile, compares each element against one broadcast operand, and returns one predicate bit per element. The bits are packed into mask words that are emitted as a stream, each word tagged with the row it belongs to. The broadcast operand is either a scalar held on a configuration input, or the first element of a second tile. In the second case that element arrives as a single beat on a dedicated operand stream.

A job starts with a one-cycle `start` pulse, which latches every configuration input. The source elements then arrive on a valid/ready stream, in row-major order and only for the valid region. The packed words leave on a second valid/ready stream. A source beat is taken only when `src_valid` and `src_ready` are both high on a rising edge. `src_ready` stays low while the block is idle, while it waits for the broadcast operand, and whenever the output holding register is full and `out_ready` is low. An output word is presented with `out_valid` and stays unchanged until `out_ready` accepts it. The operand stream is taken exactly once in tile form and never in scalar form.

Two packing widths are selectable at run time. The narrow width fills 8-bit masks. The wide width fills 32-bit masks. On the narrow width, the signed 32-bit element type only supports the equality test.

Top module: `tile_pred_cmp`

## Requirements
- R1: `cfg_mode` selects the test: 0 equal, 1 not equal, 2 less, 3 greater, 4 less-or-equal, 5 greater-or-equal. A bit is 1 when "element test operand" holds.
- R2: `cfg_type` selects the element type: 0 signed 8-bit, 1 unsigned 8-bit, 2 signed 16-bit, 3 unsigned 16-bit, 4 signed 32-bit, 5 unsigned 32-bit, 6 single-precision float. Narrow types use only the low bits of the element and of the operand. Ordered tests honour signedness.
- R3: For type 6, order follows the real value, and +0 equals -0. If either side is a NaN, every test returns 0 except not-equal, which returns 1.
- R4: With `cfg_wide`=0, words carry 8 bits in `out_word[7:0]` and bits [31:8] are zero. With `cfg_wide`=1, words carry 32 bits. The lowest column goes in bit 0.
- R5: Every valid row starts a fresh word. Unused upper bits of a row's last word are zero. `out_row` gives the row index of the word.
- R6: When `cfg_tile_form`=1, the first beat on the operand stream is captured and used for the whole job, and no further operand beat is taken. When it is 0, `cfg_scalar` is used and the operand stream is untouched.
- R7: With `cfg_wide`=0 and type 4, every mode behaves as mode 0.
- R8: A start is rejected when any of these holds: a valid count is zero, a valid count exceeds the tile size, the destination counts differ from the source counts, the mode exceeds 5, or the type exceeds 6. A rejected start pulses `cfg_err` for one cycle, takes no input, emits no word and gives no `done`.
- R9: Exactly rows x cols source beats are accepted per job. No beat is accepted while idle.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word` and `out_row` hold.
- R11: `done` pulses for one cycle in the cycle after the last word of a job is accepted. `busy` is high from the accepted start until then.
- R12: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch configuration and begin a job |
| cfg_valid_rows | input | ROW_W | Source valid row count |
| cfg_valid_cols | input | COL_W | Source valid column count |
| cfg_dst_rows | input | ROW_W | Destination valid row count |
| cfg_dst_cols | input | COL_W | Destination valid column count |
| cfg_mode | input | 3 | Comparison test |
| cfg_type | input | 3 | Element type |
| cfg_wide | input | 1 | 1 selects 32-bit masks, 0 selects 8-bit masks |
| cfg_tile_form | input | 1 | 1 takes the operand from the operand stream |
| cfg_scalar | input | 32 | Scalar operand |
| src_valid | input | 1 | Source element valid |
| src_ready | output | 1 | Source element accepted |
| src_data | input | 32 | Source element |
| opnd_valid | input | 1 | Operand element valid |
| opnd_ready | output | 1 | Operand element accepted |
| opnd_data | input | 32 | Second tile's first element |
| out_valid | output | 1 | Mask word valid |
| out_ready | input | 1 | Mask word accepted |
| out_word | output | 32 | Packed predicate word |
| out_row | output | ROW_W | Row of the word |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished (one cycle) |
| cfg_err | output | 1 | Start rejected (one cycle) |

ROW_W is $clog2(MAX_ROWS+1) and COL_W is $clog2(MAX_COLS+1).

## Verification
The bench builds the block with MAX_ROWS=4 and MAX_COLS=40. Forty columns split a wide row into a full word plus an 8-bit tail, and split a narrow row into five words. The full tile, a one-column row and both out-of-range counts (5 rows, 41 columns) then fit inside short runs. Its scoreboard also randomises output back-pressure and input gaps.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int ELEM_W   = 32;
  localparam int PRED_W   = 32;
  localparam int NARROW_W = 8;
  localparam int LANE_W   = $clog2(PRED_W);
  localparam int EXP_HI   = 30;
  localparam int EXP_LO   = 23;

  typedef enum logic [2:0] {
    CMP_EQ = 3'd0,
    CMP_NE = 3'd1,
    CMP_LT = 3'd2,
    CMP_GT = 3'd3,
    CMP_LE = 3'd4,
    CMP_GE = 3'd5
  } cmp_mode_e;

  typedef enum logic [2:0] {
    ET_S8  = 3'd0,
    ET_U8  = 3'd1,
    ET_S16 = 3'd2,
    ET_U16 = 3'd3,
    ET_S32 = 3'd4,
    ET_U32 = 3'd5,
    ET_F32 = 3'd6
  } elem_type_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_OPND,
    SQ_RUN,
    SQ_DRAIN
  } seq_state_e;
endpackage

// File: rtl/tpc_cmp_core.sv
module tpc_cmp_core
  import tpc_pkg::*;
(
  input  logic [ELEM_W-1:0] lhs,
  input  logic [ELEM_W-1:0] rhs,
  input  elem_type_e        etype,
  input  cmp_mode_e         mode,
  output logic              hit
);
  // Integer operands are widened by one bit so that signed and unsigned
  // 32-bit values share a single signed comparator.
  function automatic logic [ELEM_W:0] widen(input logic [ELEM_W-1:0] x,
                                            input elem_type_e t);
    case (t)
      ET_S8:   widen = {{(ELEM_W-7){x[7]}}, x[7:0]};
      ET_U8:   widen = {{(ELEM_W-7){1'b0}}, x[7:0]};
      ET_S16:  widen = {{(ELEM_W-15){x[15]}}, x[15:0]};
      ET_U16:  widen = {{(ELEM_W-15){1'b0}}, x[15:0]};
      ET_S32:  widen = {x[ELEM_W-1], x};
      default: widen = {1'b0, x};
    endcase
  endfunction

  // Map a float onto an unsigned key whose order matches the real value;
  // both zeros share one key.
  function automatic logic [ELEM_W-1:0] fkey(input logic [ELEM_W-1:0] x);
    if (x[ELEM_W-2:0] == '0)
      fkey = {1'b1, {(ELEM_W-1){1'b0}}};
    else if (x[ELEM_W-1])
      fkey = ~x;
    else
      fkey = {1'b1, x[ELEM_W-2:0]};
  endfunction

  function automatic logic is_nan(input logic [ELEM_W-1:0] x);
    is_nan = (&x[EXP_HI:EXP_LO]) && (|x[EXP_LO-1:0]);
  endfunction

  logic [ELEM_W:0]   wa, wb;
  logic [ELEM_W-1:0] ka, kb;
  logic              is_f, unordered, lt, eq;

  always_comb begin
    wa        = widen(lhs, etype);
    wb        = widen(rhs, etype);
    ka        = fkey(lhs);
    kb        = fkey(rhs);
    is_f      = (etype == ET_F32);
    unordered = is_f && (is_nan(lhs) || is_nan(rhs));
    lt        = is_f ? (ka < kb) : ($signed(wa) < $signed(wb));
    eq        = is_f ? (ka == kb) : (wa == wb);
    case (mode)
      CMP_EQ:  hit = eq;
      CMP_NE:  hit = !eq;
      CMP_LT:  hit = lt;
      CMP_GT:  hit = !lt && !eq;
      CMP_LE:  hit = lt || eq;
      CMP_GE:  hit = !lt;
      default: hit = 1'b0;
    endcase
    if (unordered) hit = (mode == CMP_NE);
  end
endmodule

// File: rtl/tpc_seq.sv
module tpc_seq
  import tpc_pkg::*;
#(
  parameter int MAX_ROWS = 16,
  parameter int MAX_COLS = 64,
  parameter int ROW_W    = $clog2(MAX_ROWS + 1),
  parameter int COL_W    = $clog2(MAX_COLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  cfg_rows,
  input  logic [COL_W-1:0]  cfg_cols,
  input  logic [ROW_W-1:0]  cfg_dst_rows,
  input  logic [COL_W-1:0]  cfg_dst_cols,
  input  logic [2:0]        cfg_mode,
  input  logic [2:0]        cfg_type,
  input  logic              cfg_wide,
  input  logic              cfg_tile,
  input  logic [ELEM_W-1:0] cfg_scalar,
  input  logic              opnd_fire,
  input  logic [ELEM_W-1:0] opnd_data,
  input  logic              src_fire,
  input  logic              out_fire,
  output seq_state_e        state,
  output logic [ROW_W-1:0]  row,
  output logic              last_col,
  output cmp_mode_e         mode_q,
  output elem_type_e        type_q,
  output logic              wide_q,
  output logic [ELEM_W-1:0] operand_q,
  output logic              cfg_err,
  output logic              done
);
  localparam logic [ROW_W-1:0] ROW_LIM = ROW_W'(MAX_ROWS);
  localparam logic [COL_W-1:0] COL_LIM = COL_W'(MAX_COLS);
  localparam logic [2:0]       MODE_TOP = 3'd5;
  localparam logic [2:0]       TYPE_TOP = 3'd6;

  logic [ROW_W-1:0] rows_m1;
  logic [COL_W-1:0] cols_m1, col;
  logic             bad_cfg, last_row;

  always_comb begin
    bad_cfg = (cfg_rows == '0) || (cfg_rows > ROW_LIM) ||
              (cfg_cols == '0) || (cfg_cols > COL_LIM) ||
              (cfg_rows != cfg_dst_rows) || (cfg_cols != cfg_dst_cols) ||
              (cfg_mode > MODE_TOP) || (cfg_type > TYPE_TOP);
    last_col = (col == cols_m1);
    last_row = (row == rows_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      row       <= '0;
      col       <= '0;
      rows_m1   <= '0;
      cols_m1   <= '0;
      mode_q    <= CMP_EQ;
      type_q    <= ET_S8;
      wide_q    <= 1'b0;
      operand_q <= '0;
      cfg_err   <= 1'b0;
      done      <= 1'b0;
    end else begin
      cfg_err <= 1'b0;
      done    <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          if (bad_cfg) begin
            cfg_err <= 1'b1;
          end else begin
            rows_m1   <= cfg_rows - ROW_W'(1);
            cols_m1   <= cfg_cols - COL_W'(1);
            row       <= '0;
            col       <= '0;
            type_q    <= elem_type_e'(cfg_type);
            wide_q    <= cfg_wide;
            operand_q <= cfg_scalar;
            // 32-bit signed on the narrow profile only supports equality
            mode_q    <= (!cfg_wide && (elem_type_e'(cfg_type) == ET_S32))
                         ? CMP_EQ : cmp_mode_e'(cfg_mode);
            state     <= cfg_tile ? SQ_OPND : SQ_RUN;
          end
        end
        SQ_OPND: if (opnd_fire) begin
          operand_q <= opnd_data;
          state     <= SQ_RUN;
        end
        SQ_RUN: if (src_fire) begin
          if (last_col) begin
            col <= '0;
            if (last_row) state <= SQ_DRAIN;
            else          row   <= row + ROW_W'(1);
          end else begin
            col <= col + COL_W'(1);
          end
        end
        SQ_DRAIN: if (out_fire) begin
          done  <= 1'b1;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the walk never leaves the latched region
  a_r9_region_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_RUN) |-> (row <= rows_m1) && (col <= cols_m1));
endmodule

// File: rtl/tpc_packer.sv
module tpc_packer
  import tpc_pkg::*;
#(
  parameter int ROW_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              bit_in,
  input  logic              lane_last,
  input  logic [ROW_W-1:0]  row_in,
  input  logic              wide,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [PRED_W-1:0] out_word,
  output logic [ROW_W-1:0]  out_row
);
  logic [LANE_W-1:0] lane, top_lane;
  logic [PRED_W-1:0] acc, merged;
  logic              flush;

  for (genvar g = 0; g < PRED_W; g++) begin : g_lane
    assign merged[g] = (lane == LANE_W'(g)) ? bit_in : acc[g];
  end

  always_comb begin
    top_lane = wide ? LANE_W'(PRED_W - 1) : LANE_W'(NARROW_W - 1);
    flush    = push && ((lane == top_lane) || lane_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_row   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (flush) begin
        out_valid <= 1'b1;
        out_word  <= merged;
        out_row   <= row_in;
        acc       <= '0;
        lane      <= '0;
      end else if (push) begin
        acc  <= merged;
        lane <= lane + LANE_W'(1);
      end
    end
  end

  // R10: a stalled word holds its value and tag
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_row));

  // R4: narrow masks leave the upper bits clear
  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !wide |-> (out_word[PRED_W-1:NARROW_W] == '0));
endmodule

// File: rtl/tile_pred_cmp.sv
module tile_pred_cmp
  import tpc_pkg::*;
#(
  parameter int MAX_ROWS = 16,
  parameter int MAX_COLS = 64,
  localparam int ROW_W   = $clog2(MAX_ROWS + 1),
  localparam int COL_W   = $clog2(MAX_COLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  cfg_valid_rows,
  input  logic [COL_W-1:0]  cfg_valid_cols,
  input  logic [ROW_W-1:0]  cfg_dst_rows,
  input  logic [COL_W-1:0]  cfg_dst_cols,
  input  logic [2:0]        cfg_mode,
  input  logic [2:0]        cfg_type,
  input  logic              cfg_wide,
  input  logic              cfg_tile_form,
  input  logic [ELEM_W-1:0] cfg_scalar,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [ELEM_W-1:0] src_data,
  input  logic              opnd_valid,
  output logic              opnd_ready,
  input  logic [ELEM_W-1:0] opnd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PRED_W-1:0] out_word,
  output logic [ROW_W-1:0]  out_row,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  seq_state_e        state;
  logic [ROW_W-1:0]  row;
  logic              last_col, wide_q, hit;
  cmp_mode_e         mode_q;
  elem_type_e        type_q;
  logic [ELEM_W-1:0] operand_q;
  logic              src_fire, opnd_fire, out_fire;

  always_comb begin
    busy       = (state != SQ_IDLE);
    opnd_ready = (state == SQ_OPND);
    src_ready  = (state == SQ_RUN) && (!out_valid || out_ready);
    src_fire   = src_valid && src_ready;
    opnd_fire  = opnd_valid && opnd_ready;
    out_fire   = out_valid && out_ready;
  end

  tpc_seq #(
    .MAX_ROWS (MAX_ROWS),
    .MAX_COLS (MAX_COLS),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_rows     (cfg_valid_rows),
    .cfg_cols     (cfg_valid_cols),
    .cfg_dst_rows (cfg_dst_rows),
    .cfg_dst_cols (cfg_dst_cols),
    .cfg_mode     (cfg_mode),
    .cfg_type     (cfg_type),
    .cfg_wide     (cfg_wide),
    .cfg_tile     (cfg_tile_form),
    .cfg_scalar   (cfg_scalar),
    .opnd_fire    (opnd_fire),
    .opnd_data    (opnd_data),
    .src_fire     (src_fire),
    .out_fire     (out_fire),
    .state        (state),
    .row          (row),
    .last_col     (last_col),
    .mode_q       (mode_q),
    .type_q       (type_q),
    .wide_q       (wide_q),
    .operand_q    (operand_q),
    .cfg_err      (cfg_err),
    .done         (done)
  );

  tpc_cmp_core u_cmp (
    .lhs   (src_data),
    .rhs   (operand_q),
    .etype (type_q),
    .mode  (mode_q),
    .hit   (hit)
  );

  tpc_packer #(.ROW_W(ROW_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (src_fire),
    .bit_in    (hit),
    .lane_last (last_col),
    .row_in    (row),
    .wide      (wide_q),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_row   (out_row)
  );

  // R8: a rejected start produces no traffic and no completion
  a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !out_valid && !src_ready && !done);

  // R6: the broadcast operand is taken once per job
  a_r6_operand_once: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_valid && opnd_ready |=> !opnd_ready);
endmodule

// File: tb/test_tile_pred_cmp.sv
module test_tile_pred_cmp;
  localparam int MR = 4;
  localparam int MC = 40;
  localparam int RW = $clog2(MR + 1);
  localparam int CW = $clog2(MC + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [RW-1:0] cfg_valid_rows = '0, cfg_dst_rows = '0;
  logic [CW-1:0] cfg_valid_cols = '0, cfg_dst_cols = '0;
  logic [2:0]    cfg_mode = '0, cfg_type = '0;
  logic          cfg_wide = 1'b0, cfg_tile_form = 1'b0;
  logic [31:0]   cfg_scalar = '0;
  logic          src_valid = 1'b0, src_ready;
  logic [31:0]   src_data = '0;
  logic          opnd_valid = 1'b0, opnd_ready;
  logic [31:0]   opnd_data = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [31:0]   out_word;
  logic [RW-1:0] out_row;
  logic          busy, done, cfg_err;

  tile_pred_cmp #(.MAX_ROWS(MR), .MAX_COLS(MC)) i_tile_pred_cmp (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_valid_rows(cfg_valid_rows), .cfg_valid_cols(cfg_valid_cols),
    .cfg_dst_rows(cfg_dst_rows), .cfg_dst_cols(cfg_dst_cols),
    .cfg_mode(cfg_mode), .cfg_type(cfg_type), .cfg_wide(cfg_wide),
    .cfg_tile_form(cfg_tile_form), .cfg_scalar(cfg_scalar),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .opnd_valid(opnd_valid), .opnd_ready(opnd_ready), .opnd_data(opnd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_row(out_row), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  int          n_checks = 0, n_fail = 0;
  int          done_cnt = 0, err_cnt = 0, opnd_cnt = 0, src_cnt = 0;
  int          ready_pct = 100;
  string       cur_tag = "R1";
  logic [31:0] exp_word[$];
  int          exp_row[$];
  logic [31:0] el[MR*MC];
  logic [31:0] rs = 32'h1badf00d;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic bit ref_hit(input logic [31:0] a, input logic [31:0] b,
                                 input int ty, input int md, input bit wide);
    longint x, y;
    bit lt, eq, za, zb, sa, sb;
    if (!wide && ty == 4) md = 0;
    if (ty == 6) begin
      if (((a[30:23] == 8'hFF) && (a[22:0] != 0)) ||
          ((b[30:23] == 8'hFF) && (b[22:0] != 0)))
        return md == 1;
      za = (a[30:0] == 0);
      zb = (b[30:0] == 0);
      sa = a[31] && !za;
      sb = b[31] && !zb;
      if (za && zb) begin eq = 1; lt = 0; end
      else if (sa != sb) begin eq = 0; lt = sa; end
      else begin
        eq = (a[30:0] == b[30:0]);
        lt = sa ? (a[30:0] > b[30:0]) : (a[30:0] < b[30:0]);
      end
    end else begin
      case (ty)
        0: begin x = longint'($signed(a[7:0]));  y = longint'($signed(b[7:0]));  end
        1: begin x = longint'(a[7:0]);           y = longint'(b[7:0]);           end
        2: begin x = longint'($signed(a[15:0])); y = longint'($signed(b[15:0])); end
        3: begin x = longint'(a[15:0]);          y = longint'(b[15:0]);          end
        4: begin x = longint'($signed(a));       y = longint'($signed(b));       end
        default: begin x = longint'(a);          y = longint'(b);                end
      endcase
      eq = (x == y);
      lt = (x < y);
    end
    case (md)
      0: return eq;
      1: return !eq;
      2: return lt;
      3: return !lt && !eq;
      4: return lt || eq;
      default: return !lt;
    endcase
  endfunction

  function automatic logic [31:0] pick(input int ty, input logic [31:0] op,
                                       input logic [31:0] r);
    if (ty == 6) begin
      case (r[2:0])
        3'd0: return op;
        3'd1: return 32'h0000_0000;
        3'd2: return 32'h8000_0000;
        3'd3: return 32'h3F80_0000;
        3'd4: return 32'hBF80_0000;
        3'd5: return 32'h7FC0_0000;
        3'd6: return 32'h7F80_0000;
        default: return 32'hC000_0000;
      endcase
    end
    case (r[2:0])
      3'd0: return op;
      3'd1: return op + 1;
      3'd2: return op - 1;
      3'd3: return 32'h8000_0000;
      3'd4: return {r[31:8], 8'h80};
      3'd5: return 32'h0000_7FFF;
      3'd6: return 32'hFFFF_FFFF;
      default: return r;
    endcase
  endfunction

  // Output handshake, back-pressure and scoreboard compare.
  initial forever begin
    @(negedge clk);
    out_ready = (($urandom % 100) < ready_pct);
    #1;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_word.size() == 0) begin
          chk(0, "R9", "unexpected word", {32'h0, out_word}, 64'h0);
        end else begin
          logic [31:0] w;
          int r;
          w = exp_word.pop_front();
          r = exp_row.pop_front();
          chk((out_word == w) && (int'(out_row) == r), cur_tag,
              "word (R4/R5 packing)", {28'h0, 4'(out_row), out_word},
              {28'h0, 4'(r), w});
        end
      end
      if (done)    done_cnt++;
      if (cfg_err) err_cnt++;
      if (opnd_valid && opnd_ready) opnd_cnt++;
      if (src_valid && src_ready)   src_cnt++;
    end
  end

  task automatic run_job(input string tag, input int rows, input int cols,
                         input int md, input int ty, input bit wide,
                         input bit tile, input logic [31:0] scal,
                         input logic [31:0] opv, input bit poke);
    logic [31:0] op;
    int wb, base_done, t;
    op = tile ? opv : scal;
    wb = wide ? 32 : 8;
    for (int k = 0; k < rows * cols; k++) begin
      rs = nxt(rs);
      el[k] = pick(ty, op, rs);
    end
    for (int r = 0; r < rows; r++) begin
      logic [31:0] w;
      w = '0;
      for (int c = 0; c < cols; c++) begin
        w[c % wb] = ref_hit(el[r*cols+c], op, ty, md, wide);
        if ((c % wb == wb - 1) || (c == cols - 1)) begin
          exp_word.push_back(w);
          exp_row.push_back(r);
          w = '0;
        end
      end
    end
    cur_tag = tag;
    @(negedge clk);
    base_done = done_cnt;
    opnd_cnt = 0;
    src_cnt = 0;
    cfg_valid_rows = RW'(rows); cfg_dst_rows = RW'(rows);
    cfg_valid_cols = CW'(cols); cfg_dst_cols = CW'(cols);
    cfg_mode = 3'(md); cfg_type = 3'(ty); cfg_wide = wide;
    cfg_tile_form = tile; cfg_scalar = scal;
    opnd_valid = 1'b1;
    opnd_data = tile ? opv : ~scal;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (tile) begin
      #1;
      while (!opnd_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      opnd_data = ~opv;
    end
    for (int k = 0; k < rows * cols; k++) begin
      if (($urandom % 4) == 0) begin src_valid = 1'b0; @(negedge clk); end
      start = poke && (k == 3);
      if (poke && k == 3) cfg_valid_rows = '0;
      src_valid = 1'b1;
      src_data = el[k];
      #1;
      while (!src_ready) begin @(negedge clk); start = 1'b0; #1; end
      @(negedge clk);
      start = 1'b0;
    end
    src_valid = 1'b0;
    t = 0;
    while (done_cnt == base_done && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    opnd_valid = 1'b0;
    chk(done_cnt == base_done + 1, "R11", "done pulses", done_cnt - base_done, 1);
    chk(exp_word.size() == 0, tag, "words left over", exp_word.size(), 0);
    chk(src_cnt == rows * cols, "R9", "source beats", src_cnt, rows * cols);
    chk(opnd_cnt == (tile ? 1 : 0), "R6", "operand beats", opnd_cnt, tile ? 1 : 0);
    chk(!busy, "R11", "busy after done", busy, 0);
    if (poke) chk(err_cnt == 0, "R12", "start while busy raised error", err_cnt, 0);
  endtask

  task automatic bad_job(input int rows, input int cols, input int drows,
                         input int dcols, input int md, input int ty,
                         input string what);
    int base_err, base_done;
    @(negedge clk);
    base_err = err_cnt;
    base_done = done_cnt;
    src_cnt = 0;
    opnd_cnt = 0;
    cfg_valid_rows = RW'(rows); cfg_dst_rows = RW'(drows);
    cfg_valid_cols = CW'(cols); cfg_dst_cols = CW'(dcols);
    cfg_mode = 3'(md); cfg_type = 3'(ty); cfg_wide = 1'b1;
    cfg_tile_form = 1'b1;
    start = 1'b1;
    src_valid = 1'b1; src_data = 32'h5;
    opnd_valid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(err_cnt == base_err + 1, "R8", what, err_cnt - base_err, 1);
    chk((src_cnt == 0) && (opnd_cnt == 0) && (done_cnt == base_done) && !busy,
        "R8", {what, " left quiet"}, {src_cnt[15:0], opnd_cnt[15:0]}, 0);
    src_valid = 1'b0;
    opnd_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(!out_valid && !busy && !src_ready && !done && !cfg_err, "R9",
        "state in reset", {out_valid, busy, src_ready, done, cfg_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!out_valid && !busy && !src_ready && !opnd_ready, "R9", "idle after reset",
        {out_valid, busy, src_ready, opnd_ready}, 0);

    // signed 8-bit less, operand upper bits are junk
    run_job("R2", 3, 10, 2, 0, 1'b1, 1'b0, 32'hABCD_EF05, 32'h0, 1'b0);
    // unsigned 8-bit greater-or-equal, narrow, three words a row
    run_job("R4", 2, 20, 5, 1, 1'b0, 1'b0, 32'h0000_0080, 32'h0, 1'b0);
    // signed 16-bit greater against tile operand -1
    run_job("R6", 4, 9, 3, 2, 1'b0, 1'b1, 32'h1234_5678, 32'h0000_FFFF, 1'b0);
    // unsigned 16-bit less-or-equal, full wide word plus tail
    ready_pct = 40;
    run_job("R5", 1, 40, 4, 3, 1'b1, 1'b0, 32'h0000_8000, 32'h0, 1'b0);
    // narrow signed 32-bit: less forced to equal
    run_job("R7", 2, 16, 2, 4, 1'b0, 1'b0, 32'h8000_0000, 32'h0, 1'b0);
    // wide signed 32-bit keeps less
    run_job("R2", 2, 33, 2, 4, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0, 1'b0);
    // unsigned 32-bit not-equal in tile form
    run_job("R1", 3, 32, 1, 5, 1'b1, 1'b1, 32'h0, 32'h8000_0000, 1'b0);
    // float equality against -0, less against 1.0, NaN operand, GE -1.0
    run_job("R3", 2, 12, 0, 6, 1'b1, 1'b0, 32'h8000_0000, 32'h0, 1'b0);
    run_job("R3", 2, 12, 2, 6, 1'b0, 1'b1, 32'h0, 32'h3F80_0000, 1'b0);
    run_job("R3", 1, 16, 1, 6, 1'b1, 1'b0, 32'h7FC0_0000, 32'h0, 1'b0);
    run_job("R3", 1, 16, 5, 6, 1'b1, 1'b0, 32'hBF80_0000, 32'h0, 1'b0);
    // full tile under heavy back-pressure, start poked mid-job
    ready_pct = 25;
    run_job("R10", 4, 40, 3, 0, 1'b1, 1'b0, 32'h0000_0010, 32'h0, 1'b1);
    // one-column rows: each element is its own word
    ready_pct = 70;
    run_job("R5", 4, 1, 4, 1, 1'b0, 1'b0, 32'h0000_0040, 32'h0, 1'b0);
    ready_pct = 100;

    bad_job(0, 4, 0, 4, 0, 0, "zero rows");
    bad_job(5, 4, 5, 4, 0, 0, "rows over tile");
    bad_job(2, 41, 2, 41, 0, 0, "cols over tile");
    bad_job(2, 0, 2, 0, 0, 0, "zero cols");
    bad_job(2, 4, 3, 4, 0, 0, "dst rows differ");
    bad_job(2, 4, 2, 5, 0, 0, "dst cols differ");
    bad_job(2, 4, 2, 4, 6, 0, "mode out of range");
    bad_job(2, 4, 2, 4, 0, 7, "type out of range");

    // the block still runs normally after rejections
    run_job("R1", 2, 8, 0, 1, 1'b0, 1'b0, 32'h0000_00FF, 32'h0, 1'b0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule